// File: doc/BRIEF.md
# Indirect-Access Mailbox and Shared-RAM Bridge

This block is the target end of a narrow local bus on which a host reaches every internal resource through three bus offsets: a high address latch, a low address latch and a data port. The two latches form an internal pointer. When the pointer's high byte is below 0x80 it selects one of a set of byte-wide control registers (identity bytes, revisions, fan speed bytes, a build stamp and two one-byte mailboxes). When it is 0x80 or above it selects a word of a 16-bit shared RAM, and each data-port access steps the pointer to the next word, so a message is streamed without rewriting the address.

A host sends a message by filling RAM words and then writing a command byte into the host-to-peer mailbox. That write pulses an interrupt towards the peer and sets a pending flag, which the peer clears when it reads the mailbox. The peer answers by writing the peer-to-host mailbox, which raises a host interrupt held until the host reads that register, and the host then reads the reply from RAM. The peer side has a direct RAM port and its own mailbox strobes. The peer's own logic lies outside this block.

Top module: `mbx_bridge`

## Requirements
- R1: Bus offset 0x00 loads the pointer's high byte and offset 0x01 loads its low byte from bus_wdata[7:0]; offset 0x80 is the data port; bus accesses at any other offset change nothing.
- R2: In register space (high byte below 0x80, low byte ignored) a data-port read returns, in bus_rdata[7:0] with bits 15:8 zero: 0xA5 at 0x00, 0x5A at 0x01, the hardware revision (default 0x03) at 0x02 and the logic revision (default 0x11) at 0x03; host writes to these leave them unchanged.
- R3: In the RAM window (high byte 0x80 or above) the word index is {high[6:0], low}; data-port writes store bus_wdata and reads return the stored 16-bit word.
- R4: Every data-port access, read or write, in the RAM window advances the 15-bit index by one; accesses in register space leave the pointer unchanged.
- R5: An index at or beyond RAM_WORDS reads as 0x0000 and writes to it change no RAM word; the pointer still advances.
- R6: A host write of register 0x04 stores the byte, shown on peer_cmd and read back at 0x04, and in the next cycle peer_irq is high for exactly one cycle while peer_pending becomes 1.
- R7: peer_mbox_rd clears peer_pending in the next cycle; when it coincides with a host write of 0x04 the flag stays set.
- R8: peer_mbox_wr stores peer_mbox_wdata and sets host_irq in the next cycle; a host read of 0x05 returns that byte and clears host_irq unless a peer write coincides; host writes to 0x05 are ignored.
- R9: Fan k (k from 0, 16 bits at fan_rps[16k+15:16k]) reads its high byte at 0x10+2k and low byte at 0x11+2k; the 32-bit build stamp reads most significant byte first at 0x20..0x23.
- R10: Any other register address reads as 0x00 and ignores writes.
- R11: The peer RAM port writes at the clock edge and reads combinationally; when host and peer write the same word in one cycle the host's value is kept.
- R12: After reset peer_irq, peer_pending and host_irq are 0, both mailboxes hold 0x00 and the pointer is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Host access strobe, one access per cycle |
| bus_we | input | 1 | Host access is a write |
| bus_addr | input | 8 | Host bus offset |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data for the current pointer |
| fan_rps | input | NUM_FANS*16 | Fan speed values |
| peer_ram_we | input | 1 | Peer RAM write enable |
| peer_ram_addr | input | RAM_IDX_W | Peer RAM word index |
| peer_ram_wdata | input | 16 | Peer RAM write data |
| peer_ram_rdata | output | 16 | Peer RAM read data |
| peer_mbox_rd | input | 1 | Peer consumes the host-to-peer mailbox |
| peer_mbox_wr | input | 1 | Peer writes the peer-to-host mailbox |
| peer_mbox_wdata | input | 8 | Peer mailbox write byte |
| peer_cmd | output | 8 | Host-to-peer mailbox content |
| peer_irq | output | 1 | One-cycle notification of a host mailbox write |
| peer_pending | output | 1 | Host mailbox written and not yet consumed |
| host_irq | output | 1 | Peer mailbox written and not yet read |

## Verification
On every cycle the assertions check the mailbox handshakes (the single-cycle peer pulse tied to a host mailbox write, pending and host interrupt set and clear ordering), the pointer stepping in the RAM window and holding in register space, and zero reads past the end of the RAM. Only the bench scenarios can show data content: the full register map values, words streamed by the host appearing on the peer port and the reverse, start offsets other than zero, that an out-of-range write leaves the aliased word intact, and the same-word write collision.

// File: rtl/mbx_bridge_pkg.sv
package mbx_bridge_pkg;
  localparam int WORD_W = 16;
  localparam int PTR_W  = 15;

  localparam logic [7:0] OFS_PTR_HI = 8'h00;
  localparam logic [7:0] OFS_PTR_LO = 8'h01;
  localparam logic [7:0] OFS_DATA   = 8'h80;

  localparam logic [7:0] REG_ID0    = 8'h00;
  localparam logic [7:0] REG_ID1    = 8'h01;
  localparam logic [7:0] REG_HWREV  = 8'h02;
  localparam logic [7:0] REG_LGREV  = 8'h03;
  localparam logic [7:0] REG_H2P    = 8'h04;
  localparam logic [7:0] REG_P2H    = 8'h05;
  localparam logic [7:0] REG_FAN0   = 8'h10;
  localparam logic [7:0] REG_STAMP0 = 8'h20;
endpackage

// File: rtl/mbx_ptr.sv
module mbx_ptr
  import mbx_bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_hi,
  input  logic       ld_lo,
  input  logic       step,
  input  logic [7:0] din,
  output logic [7:0] ptr_hi,
  output logic [7:0] ptr_lo
);
  logic [7:0]       hi_d, lo_d;
  logic [PTR_W-1:0] idx_inc;

  assign idx_inc = {ptr_hi[6:0], ptr_lo} + PTR_W'(1);

  always_comb begin
    hi_d = ptr_hi;
    lo_d = ptr_lo;
    if (ld_hi) begin
      hi_d = din;
    end else if (ld_lo) begin
      lo_d = din;
    end else if (step) begin
      hi_d = {ptr_hi[7], idx_inc[PTR_W-1:8]};
      lo_d = idx_inc[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_hi <= '0;
      ptr_lo <= '0;
    end else if (ld_hi || ld_lo || step) begin
      ptr_hi <= hi_d;
      ptr_lo <= lo_d;
    end
  end
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       h2p_wr,
  input  logic [7:0] h2p_din,
  input  logic       h2p_take,
  input  logic       p2h_wr,
  input  logic [7:0] p2h_din,
  input  logic       p2h_take,
  output logic [7:0] h2p_q,
  output logic [7:0] p2h_q,
  output logic       peer_irq,
  output logic       peer_pending,
  output logic       host_irq
);
  logic pend_d, hirq_d;

  always_comb begin
    pend_d = peer_pending;
    if (h2p_take) pend_d = 1'b0;
    if (h2p_wr)   pend_d = 1'b1;
    hirq_d = host_irq;
    if (p2h_take) hirq_d = 1'b0;
    if (p2h_wr)   hirq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h2p_q <= '0;
    end else if (h2p_wr) begin
      h2p_q <= h2p_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p2h_q <= '0;
    end else if (p2h_wr) begin
      p2h_q <= p2h_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peer_irq     <= 1'b0;
      peer_pending <= 1'b0;
      host_irq     <= 1'b0;
    end else begin
      peer_irq     <= h2p_wr;
      peer_pending <= pend_d;
      host_irq     <= hirq_d;
    end
  end
endmodule

// File: rtl/mbx_ram.sv
module mbx_ram #(
  parameter int WORDS  = 2048,
  parameter int WIDTH  = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             a_we,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [WIDTH-1:0] a_wd,
  output logic [WIDTH-1:0] a_rd,
  input  logic             b_we,
  input  logic [IDX_W-1:0] b_idx,
  input  logic [WIDTH-1:0] b_wd,
  output logic [WIDTH-1:0] b_rd
);
  logic [WIDTH-1:0] mem [WORDS];

  // Port A (host) is written last so it wins a same-word collision.
  always_ff @(posedge clk) begin
    if (b_we) mem[b_idx] <= b_wd;
    if (a_we) mem[a_idx] <= a_wd;
  end

  assign a_rd = mem[a_idx];
  assign b_rd = mem[b_idx];
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
  import mbx_bridge_pkg::*;
#(
  parameter int          RAM_WORDS   = 2048,
  parameter int          NUM_FANS    = 3,
  parameter logic [7:0]  ID0         = 8'hA5,
  parameter logic [7:0]  ID1         = 8'h5A,
  parameter logic [7:0]  HW_REV      = 8'h03,
  parameter logic [7:0]  LOGIC_REV   = 8'h11,
  parameter logic [31:0] BUILD_STAMP = 32'h2024_0117,
  localparam int RAM_IDX_W = $clog2(RAM_WORDS),
  localparam int FAN_W     = NUM_FANS * 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_cs,
  input  logic                 bus_we,
  input  logic [7:0]           bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  input  logic [FAN_W-1:0]     fan_rps,
  input  logic                 peer_ram_we,
  input  logic [RAM_IDX_W-1:0] peer_ram_addr,
  input  logic [WORD_W-1:0]    peer_ram_wdata,
  output logic [WORD_W-1:0]    peer_ram_rdata,
  input  logic                 peer_mbox_rd,
  input  logic                 peer_mbox_wr,
  input  logic [7:0]           peer_mbox_wdata,
  output logic [7:0]           peer_cmd,
  output logic                 peer_irq,
  output logic                 peer_pending,
  output logic                 host_irq
);
  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // Bus decode.
  logic             ptr_hi_ld, ptr_lo_ld, data_acc, in_ram, ram_acc;
  logic             reg_wr, reg_rd, in_range;
  logic [7:0]       ptr_hi, ptr_lo;
  logic [PTR_W-1:0] win_idx;

  assign ptr_hi_ld = bus_cs && bus_we && (bus_addr == OFS_PTR_HI);
  assign ptr_lo_ld = bus_cs && bus_we && (bus_addr == OFS_PTR_LO);
  assign data_acc  = bus_cs && (bus_addr == OFS_DATA);
  assign in_ram    = ptr_hi[7];
  assign ram_acc   = data_acc && in_ram;
  assign reg_wr    = data_acc && bus_we && !in_ram;
  assign reg_rd    = data_acc && !bus_we && !in_ram;
  assign win_idx   = {ptr_hi[6:0], ptr_lo};
  assign in_range  = ({17'd0, win_idx} < 32'(RAM_WORDS));

  mbx_ptr u_ptr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .ld_hi  (ptr_hi_ld),
    .ld_lo  (ptr_lo_ld),
    .step   (ram_acc),
    .din    (bus_wdata[7:0]),
    .ptr_hi (ptr_hi),
    .ptr_lo (ptr_lo)
  );

  // Mailboxes.
  logic [7:0] h2p_q, p2h_q;
  logic       h2p_wr, p2h_take;

  assign h2p_wr   = reg_wr && (ptr_hi == REG_H2P);
  assign p2h_take = reg_rd && (ptr_hi == REG_P2H);

  mbx_mailbox u_mbox (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .h2p_wr       (h2p_wr),
    .h2p_din      (bus_wdata[7:0]),
    .h2p_take     (peer_mbox_rd),
    .p2h_wr       (peer_mbox_wr),
    .p2h_din      (peer_mbox_wdata),
    .p2h_take     (p2h_take),
    .h2p_q        (h2p_q),
    .p2h_q        (p2h_q),
    .peer_irq     (peer_irq),
    .peer_pending (peer_pending),
    .host_irq     (host_irq)
  );
  assign peer_cmd = h2p_q;

  // Shared RAM.
  logic [WORD_W-1:0] host_ram_rd;

  mbx_ram #(.WORDS(RAM_WORDS), .WIDTH(WORD_W)) u_ram (
    .clk   (clk),
    .a_we  (ram_acc && bus_we && in_range),
    .a_idx (win_idx[RAM_IDX_W-1:0]),
    .a_wd  (bus_wdata),
    .a_rd  (host_ram_rd),
    .b_we  (peer_ram_we),
    .b_idx (peer_ram_addr),
    .b_wd  (peer_ram_wdata),
    .b_rd  (peer_ram_rdata)
  );

  // Register read mux.
  logic [7:0] reg_byte;

  always_comb begin
    reg_byte = 8'h00;
    case (ptr_hi)
      REG_ID0:   reg_byte = ID0;
      REG_ID1:   reg_byte = ID1;
      REG_HWREV: reg_byte = HW_REV;
      REG_LGREV: reg_byte = LOGIC_REV;
      REG_H2P:   reg_byte = h2p_q;
      REG_P2H:   reg_byte = p2h_q;
      default:   reg_byte = 8'h00;
    endcase
    for (int k = 0; k < NUM_FANS; k++) begin
      if (ptr_hi == REG_FAN0 + 8'(2 * k))     reg_byte = fan_rps[16*k+8 +: 8];
      if (ptr_hi == REG_FAN0 + 8'(2 * k + 1)) reg_byte = fan_rps[16*k +: 8];
    end
    for (int s = 0; s < 4; s++) begin
      if (ptr_hi == REG_STAMP0 + 8'(s)) reg_byte = BUILD_STAMP[8*(3-s) +: 8];
    end
  end

  always_comb begin
    if (in_ram) bus_rdata = in_range ? host_ram_rd : '0;
    else        bus_rdata = {8'h00, reg_byte};
  end
endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk #(
  parameter int RAM_WORDS = 2048
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_cs,
  input logic        bus_we,
  input logic [7:0]  bus_addr,
  input logic [15:0] bus_rdata,
  input logic [7:0]  ptr_hi,
  input logic [7:0]  ptr_lo,
  input logic        peer_mbox_rd,
  input logic        peer_mbox_wr,
  input logic        peer_irq,
  input logic        peer_pending,
  input logic        host_irq
);
  logic        dacc, h2p_w, p2h_r;
  logic [14:0] idx;

  assign dacc  = bus_cs && (bus_addr == 8'h80);
  assign h2p_w = dacc && bus_we && (ptr_hi == 8'h04);
  assign p2h_r = dacc && !bus_we && (ptr_hi == 8'h05);
  assign idx   = {ptr_hi[6:0], ptr_lo};

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    peer_irq |-> $past(h2p_w));
  assert_irq_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    peer_irq |-> peer_pending);
  assert_pend_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_mbox_rd && !h2p_w) |=> !peer_pending);
  assert_hirq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    peer_mbox_wr |=> host_irq);
  assert_hirq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (p2h_r && !peer_mbox_wr) |=> !host_irq);
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dacc && ptr_hi[7]) |=> (ptr_hi[7] && ({ptr_hi[6:0], ptr_lo} == $past(idx) + 15'd1)));
  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dacc && !ptr_hi[7]) |=> ($stable(ptr_hi) && $stable(ptr_lo)));
  assert_oob_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_hi[7] && ({17'd0, idx} >= 32'(RAM_WORDS))) |-> (bus_rdata == 16'h0000));
endmodule

bind mbx_bridge mbx_bridge_chk #(.RAM_WORDS(RAM_WORDS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .bus_cs       (bus_cs),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_rdata    (bus_rdata),
  .ptr_hi       (ptr_hi),
  .ptr_lo       (ptr_lo),
  .peer_mbox_rd (peer_mbox_rd),
  .peer_mbox_wr (peer_mbox_wr),
  .peer_irq     (peer_irq),
  .peer_pending (peer_pending),
  .host_irq     (host_irq)
);

// File: tb/mbx_bridge_test.sv
module mbx_bridge_test;
  localparam int W     = 64;
  localparam int IDX_W = 6;
  localparam logic [47:0] FANS = {16'h0C1D, 16'hB2A3, 16'h1234};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        peer_ram_we = 1'b0;
  logic [5:0]  peer_ram_addr = '0;
  logic [15:0] peer_ram_wdata = '0;
  logic [15:0] peer_ram_rdata;
  logic        peer_mbox_rd = 1'b0, peer_mbox_wr = 1'b0;
  logic [7:0]  peer_mbox_wdata = '0;
  logic [7:0]  peer_cmd;
  logic        peer_irq, peer_pending, host_irq;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] m_h2p = 8'h00, m_p2h = 8'h00;

  always #10 clk = ~clk;

  mbx_bridge #(.RAM_WORDS(W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fan_rps(FANS), .peer_ram_we(peer_ram_we), .peer_ram_addr(peer_ram_addr),
    .peer_ram_wdata(peer_ram_wdata), .peer_ram_rdata(peer_ram_rdata),
    .peer_mbox_rd(peer_mbox_rd), .peer_mbox_wr(peer_mbox_wr),
    .peer_mbox_wdata(peer_mbox_wdata), .peer_cmd(peer_cmd),
    .peer_irq(peer_irq), .peer_pending(peer_pending), .host_irq(host_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(input logic [7:0] a);
    case (a)
      8'h00: return 8'hA5;
      8'h01: return 8'h5A;
      8'h02: return 8'h03;
      8'h03: return 8'h11;
      8'h04: return m_h2p;
      8'h05: return m_p2h;
      8'h10: return FANS[15:8];
      8'h11: return FANS[7:0];
      8'h12: return FANS[31:24];
      8'h13: return FANS[23:16];
      8'h14: return FANS[47:40];
      8'h15: return FANS[39:32];
      8'h20: return 8'h20;
      8'h21: return 8'h24;
      8'h22: return 8'h01;
      8'h23: return 8'h17;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] pat_a(input int i);
    return 16'(i * 16'h0101) ^ 16'h5A3C;
  endfunction
  function automatic logic [15:0] pat_b(input int i);
    return 16'hC000 | 16'(i * 7);
  endfunction

  task automatic bus_wr(input logic [7:0] ofs, input logic [15:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = ofs; bus_wdata = d;
    @(posedge clk); #1;
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] ofs, output logic [15:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = ofs;
    #5 d = bus_rdata;
    @(posedge clk); #1;
    bus_cs = 1'b0;
  endtask

  task automatic peer_rd(input int i, output logic [15:0] d);
    @(negedge clk);
    peer_ram_addr = 6'(i);
    #5 d = peer_ram_rdata;
  endtask

  task automatic reg_sweep(input string tag);
    logic [15:0] v;
    for (int a = 0; a < 128; a++) begin
      bus_wr(8'h00, 16'(a));
      bus_rd(8'h80, v);
      chk(tag, v, {8'h00, exp_reg(8'(a))});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R12 reset state
    chk("R12 peer_irq", peer_irq, 0);
    chk("R12 pending", peer_pending, 0);
    chk("R12 host_irq", host_irq, 0);
    chk("R12 peer_cmd", peer_cmd, 0);
    bus_rd(8'h80, v);
    chk("R12 ptr=0 reads id0", v, 16'h00A5);

    // R2 R9 R10 full register map
    reg_sweep("R2/R9/R10 map");

    // R10 R2 writes to read-only and unmapped are ignored
    for (int a = 0; a < 128; a++) begin
      if (a != 4) begin
        bus_wr(8'h00, 16'(a));
        bus_wr(8'h80, 16'hFFFF);
      end
    end
    reg_sweep("R10 writes ignored");
    chk("R10 peer_irq after ignored writes", peer_pending, 0);

    // R1 other offsets ignored, low byte ignored in register space
    bus_wr(8'h00, 16'h02);
    bus_wr(8'h02, 16'h00);
    bus_wr(8'h7F, 16'h00);
    bus_wr(8'h01, 16'h33);
    bus_rd(8'h80, v);
    chk("R1 stray offsets", v, 16'h0003);
    bus_rd(8'h80, v);
    chk("R4 register space no step", v, 16'h0003);

    // R6 host mailbox write
    bus_wr(8'h00, 16'h04);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = 8'h80; bus_wdata = 16'h003C;
    @(posedge clk); #1;
    bus_cs = 1'b0; bus_we = 1'b0;
    m_h2p = 8'h3C;
    chk("R6 peer_irq pulse", peer_irq, 1);
    chk("R6 pending set", peer_pending, 1);
    chk("R6 peer_cmd", peer_cmd, 8'h3C);
    @(posedge clk); #1;
    chk("R6 pulse one cycle", peer_irq, 0);
    bus_rd(8'h80, v);
    chk("R6 host readback", v, 16'h003C);

    // R7 peer consume
    @(negedge clk); peer_mbox_rd = 1'b1;
    @(posedge clk); #1; peer_mbox_rd = 1'b0;
    chk("R7 pending cleared", peer_pending, 0);
    @(negedge clk);
    peer_mbox_rd = 1'b1;
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = 8'h80; bus_wdata = 16'h00C7;
    @(posedge clk); #1;
    peer_mbox_rd = 1'b0; bus_cs = 1'b0; bus_we = 1'b0;
    m_h2p = 8'hC7;
    chk("R7 set wins over clear", peer_pending, 1);

    // R8 peer-to-host mailbox
    @(negedge clk); peer_mbox_wr = 1'b1; peer_mbox_wdata = 8'h9E;
    @(posedge clk); #1; peer_mbox_wr = 1'b0;
    m_p2h = 8'h9E;
    chk("R8 host_irq set", host_irq, 1);
    bus_wr(8'h00, 16'h05);
    bus_wr(8'h80, 16'h0011);
    chk("R8 host write keeps irq", host_irq, 1);
    bus_rd(8'h80, v);
    chk("R8 host reads mailbox", v, 16'h009E);
    chk("R8 host_irq cleared", host_irq, 0);
    reg_sweep("R8 map after mailboxes");

    // R3 R4 host fills RAM, peer reads
    bus_wr(8'h00, 16'h80);
    bus_wr(8'h01, 16'h00);
    for (int i = 0; i < W; i++) bus_wr(8'h80, pat_a(i));
    for (int i = 0; i < W; i++) begin
      peer_rd(i, v);
      chk("R3/R4/R11 peer sees host word", v, pat_a(i));
    end

    // R11 peer fills RAM, host streams it back
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      peer_ram_we = 1'b1; peer_ram_addr = 6'(i); peer_ram_wdata = pat_b(i);
      @(posedge clk); #1; peer_ram_we = 1'b0;
    end
    bus_wr(8'h00, 16'h80);
    bus_wr(8'h01, 16'h00);
    for (int i = 0; i < W; i++) begin
      bus_rd(8'h80, v);
      chk("R4/R11 host stream read", v, pat_b(i));
    end
    // R5 pointer ran to index 64: out of range
    bus_rd(8'h80, v);
    chk("R5 out of range read", v, 0);

    // R3 nonzero start offset
    bus_wr(8'h00, 16'h80);
    bus_wr(8'h01, 16'h20);
    for (int i = 32; i < 40; i++) begin
      bus_rd(8'h80, v);
      chk("R3 offset read", v, pat_b(i));
    end

    // R5 write past end leaves aliased word 0 intact
    bus_wr(8'h00, 16'h80);
    bus_wr(8'h01, 16'h3F);
    bus_wr(8'h80, 16'h7777);
    bus_wr(8'h80, 16'hDEAD);
    peer_rd(63, v);
    chk("R5 last word written", v, 16'h7777);
    peer_rd(0, v);
    chk("R5 oob write ignored", v, pat_b(0));

    // R11 collision: host wins
    bus_wr(8'h00, 16'h80);
    bus_wr(8'h01, 16'h05);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = 8'h80; bus_wdata = 16'hAAAA;
    peer_ram_we = 1'b1; peer_ram_addr = 6'd5; peer_ram_wdata = 16'hBBBB;
    @(posedge clk); #1;
    bus_cs = 1'b0; bus_we = 1'b0; peer_ram_we = 1'b0;
    peer_rd(5, v);
    chk("R11 host wins collision", v, 16'hAAAA);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule